// File: doc/BRIEF.md
# Serial Bus Command Frame Encoder

This block turns one bus request into the bit stream of an address-and-data command frame for the master side of a two-wire serial service bus. A request names a target slave (2-bit id), a byte address, an access size of 1, 2 or 4 bytes, a read or write direction and up to four write bytes. Only the low 21 bits of the address are used.

To keep frames short, the block remembers the last address it sent to each of the four slaves. If the new address falls in the same 4-byte word, it uses a short "same word" form that carries only two address bits. If the new address is within a signed 9-bit offset of the previous one, it uses a "relative" form. Otherwise it sends the full address. The access size is folded into the low bits of the address field together with a size flag. The frame then takes a 4-bit CRC and leaves the block one bit per cycle, with a strobe on each bit and a completion pulse at the end.

The request side uses a valid/ready handshake. A request is taken only while no frame is being sent. Response decoding, retries, line timing and clock generation are handled elsewhere.

Top module: `sbus_cmd_encoder`

## Requirements
- R1: Only bits 20:0 of `req_addr` are used. Bits above 20 have no effect on the address field or on form selection.
- R2: If the slave's history entry is valid and the new masked address equals it in bits 20:2, the frame uses opcode 2'b11 and a 2-bit address field taken from address bits 1:0.
- R3: If R2 does not apply, the entry is valid and (new − previous) lies in −256..+255, the frame uses opcode 3'b101 and a 9-bit two's-complement offset field.
- R4: In every other case the frame uses opcode 3'b100 and the full 21-bit masked address. This includes an invalid entry and offsets of +256 or −257.
- R5: Frame bits are sent in this order: id (2), opcode, direction bit (1 = read, 0 = write), address field, size flag (1), data bytes, CRC. Every field is sent MSB first.
- R6: `req_size` code 2'b00 means 1 byte: size flag 0, field unchanged. Code 2'b01 means 2 bytes: size flag 1, field bit 0 cleared. Codes 2'b10 and 2'b11 mean 4 bytes: size flag 1, field bits 1:0 forced to 01. This applies to all three address forms.
- R7: A write carries exactly as many bytes as its size, starting with `req_wdata[7:0]` and then going up in byte order. A read carries no data bytes.
- R8: The frame ends with a 4-bit CRC. It uses polynomial x^4+x+1 with a zero seed, covers every earlier frame bit, and is sent MSB first.
- R9: Each of the four slaves has its own history entry. The entry is loaded with the full masked address when that slave's frame completes. Reset marks all entries invalid.
- R10: `req_ready` is high only when idle. Frame bits come on consecutive cycles with `bit_valid` high, starting the cycle after acceptance. `frame_done` pulses for one cycle right after the last CRC bit, with `bit_valid` low. The block is ready again in the following cycle. After reset it is ready, and `bit_valid` and `frame_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken when valid |
| req_id | input | 2 | Target slave id |
| req_addr | input | 32 | Byte address (bits 20:0 used) |
| req_size | input | 2 | Access size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Write bytes, byte 0 in bits 7:0 |
| bit_valid | output | 1 | Frame bit present on bit_data |
| bit_data | output | 1 | Serial frame bit |
| frame_done | output | 1 | One-cycle pulse after the last CRC bit |

## Verification
The embedded properties check the handshake and timing rules of R10 on every cycle:
- no acceptance while busy,
- the first bit follows acceptance,
- the completion pulse is single and follows the last bit.

They also check that the CRC phase always lasts four bits and that a completed frame marks its slave's entry valid.

Form selection, field packing, size folding, byte order and the CRC value can only be shown by the bench's scenarios. Each scenario compares the whole serial stream against a frame built by hand from the requirements. The scenarios cover both ends of the relative range and the first values just outside it, upper address bits full of junk, slaves that share nearby addresses, and a reset that clears the history.

// File: rtl/sbus_enc_pkg.sv
package sbus_enc_pkg;

  localparam int ID_W      = 2;
  localparam int ADDR_W    = 21;
  localparam int REL_W     = 9;
  localparam int CRC_W     = 4;
  localparam int BYTES_MAX = 4;

  typedef enum logic [1:0] {
    FORM_ABS  = 2'd0,
    FORM_REL  = 2'd1,
    FORM_SAME = 2'd2
  } form_e;

  localparam logic [2:0] OPC_ABS  = 3'b100;
  localparam logic [2:0] OPC_REL  = 3'b101;
  localparam logic [1:0] OPC_SAME = 2'b11;

  localparam logic [1:0] SZ_ONE = 2'b00;
  localparam logic [1:0] SZ_TWO = 2'b01;

  localparam logic [CRC_W-1:0] CRC_POLY = 4'h3;

endpackage

// File: rtl/sbus_addr_history.sv
module sbus_addr_history
  import sbus_enc_pkg::*;
#(
  parameter int P_ID_W   = ID_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_REL_W  = REL_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [P_ID_W-1:0]   lk_id,
  input  logic [P_ADDR_W-1:0] lk_addr,
  output form_e               lk_form,
  output logic [P_REL_W-1:0]  lk_delta,
  input  logic                upd_en,
  input  logic [P_ID_W-1:0]   upd_id,
  input  logic [P_ADDR_W-1:0] upd_addr
);

  localparam int NUM_SLV = 1 << P_ID_W;
  localparam int DIFF_W  = P_ADDR_W + 1;
  localparam int TOP_W   = DIFF_W - (P_REL_W - 1);

  logic [P_ADDR_W-1:0] last_q [NUM_SLV];
  logic [NUM_SLV-1:0]  vld_q;
  logic [NUM_SLV-1:0]  upd_hit;

  // one entry per slave id
  for (genvar s = 0; s < NUM_SLV; s++) begin : g_slot
    assign upd_hit[s] = upd_en && (upd_id == P_ID_W'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[s] <= 1'b0;
      end else if (upd_hit[s]) begin
        vld_q[s] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (upd_hit[s]) begin
        last_q[s] <= upd_addr;
      end
    end
  end

  logic [P_ADDR_W-1:0] prev_addr;
  logic                prev_vld;
  logic [DIFF_W-1:0]   diff;
  logic [TOP_W-1:0]    diff_top;
  logic                same_word;
  logic                in_reach;

  always_comb begin
    prev_addr = last_q[lk_id];
    prev_vld  = vld_q[lk_id];
    diff      = {1'b0, lk_addr} - {1'b0, prev_addr};
    diff_top  = diff[DIFF_W-1:P_REL_W-1];
    same_word = prev_vld && (lk_addr[P_ADDR_W-1:2] == prev_addr[P_ADDR_W-1:2]);
    in_reach  = prev_vld && ((&diff_top) || !(|diff_top));
    lk_delta  = diff[P_REL_W-1:0];
    if (same_word) begin
      lk_form = FORM_SAME;
    end else if (in_reach) begin
      lk_form = FORM_REL;
    end else begin
      lk_form = FORM_ABS;
    end
  end

  AST_UPD_MARKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |=> vld_q[$past(upd_id)]); // R9

endmodule

// File: rtl/sbus_frame_pack.sv
module sbus_frame_pack
  import sbus_enc_pkg::*;
#(
  parameter int P_ID_W   = ID_W,
  parameter int P_ADDR_W = ADDR_W,
  parameter int P_REL_W  = REL_W,
  parameter int P_BYTES  = BYTES_MAX,
  parameter int FRAME_MAX = P_ID_W + 3 + 1 + P_ADDR_W + 1 + 8 * P_BYTES,
  parameter int LEN_W    = $clog2(FRAME_MAX + 1)
) (
  input  logic [P_ID_W-1:0]    id,
  input  form_e                form,
  input  logic                 write,
  input  logic [P_ADDR_W-1:0]  abs_addr,
  input  logic [P_REL_W-1:0]   delta,
  input  logic [1:0]           size,
  input  logic [8*P_BYTES-1:0] wdata,
  output logic [FRAME_MAX-1:0] frame,
  output logic [LEN_W-1:0]     len
);

  logic [P_ADDR_W-1:0]  fld;
  int unsigned          fld_w;
  logic [2:0]           opc;
  int unsigned          opc_w;
  logic                 ds;
  int unsigned          nbytes;
  logic [FRAME_MAX-1:0] acc;
  int unsigned          n;

  // address field and opcode per form, size folded into low bits
  always_comb begin
    fld   = '0;
    fld_w = P_ADDR_W;
    opc   = OPC_ABS;
    opc_w = 3;
    unique case (form)
      FORM_SAME: begin
        fld   = P_ADDR_W'(abs_addr[1:0]);
        fld_w = 2;
        opc   = {1'b0, OPC_SAME};
        opc_w = 2;
      end
      FORM_REL: begin
        fld   = P_ADDR_W'(delta);
        fld_w = P_REL_W;
        opc   = OPC_REL;
      end
      default: begin
        fld   = abs_addr;
      end
    endcase
    ds     = (size != SZ_ONE);
    nbytes = 1;
    if (size == SZ_TWO) begin
      fld[0] = 1'b0;
      nbytes = 2;
    end else if (size[1]) begin
      fld[1:0] = 2'b01;
      nbytes   = P_BYTES;
    end
  end

  // fields shifted in from the right, then left aligned
  always_comb begin
    acc = '0;
    n   = 0;
    acc = (acc << P_ID_W) | FRAME_MAX'(id);
    n   = n + P_ID_W;
    acc = (acc << opc_w) | FRAME_MAX'(opc);
    n   = n + opc_w;
    acc = (acc << 1) | FRAME_MAX'(!write);
    n   = n + 1;
    acc = (acc << fld_w) | FRAME_MAX'(fld);
    n   = n + fld_w;
    acc = (acc << 1) | FRAME_MAX'(ds);
    n   = n + 1;
    for (int b = 0; b < P_BYTES; b++) begin
      if (write && (b < int'(nbytes))) begin
        acc = (acc << 8) | FRAME_MAX'(wdata[8*b +: 8]);
        n   = n + 8;
      end
    end
    frame = acc << (FRAME_MAX - n);
    len   = LEN_W'(n);
  end

endmodule

// File: rtl/sbus_bit_shifter.sv
module sbus_bit_shifter
  import sbus_enc_pkg::*;
#(
  parameter int FRAME_MAX = 60,
  parameter int LEN_W     = $clog2(FRAME_MAX + 1),
  parameter int P_CRC_W   = CRC_W,
  parameter logic [P_CRC_W-1:0] P_POLY = CRC_POLY
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [FRAME_MAX-1:0] frame_in,
  input  logic [LEN_W-1:0]     len_in,
  output logic                 idle,
  output logic                 bit_valid,
  output logic                 bit_data,
  output logic                 done
);

  typedef enum logic [1:0] {SH_IDLE, SH_BODY, SH_CRC, SH_DONE} sh_state_e;

  sh_state_e            state_q, state_d;
  logic [FRAME_MAX-1:0] shreg_q, shreg_d;
  logic [LEN_W-1:0]     cnt_q, cnt_d;
  logic [P_CRC_W-1:0]   crc_q, crc_d;
  logic                 fb;

  always_comb begin
    state_d = state_q;
    shreg_d = shreg_q;
    cnt_d   = cnt_q;
    crc_d   = crc_q;
    fb      = crc_q[P_CRC_W-1] ^ shreg_q[FRAME_MAX-1];
    unique case (state_q)
      SH_IDLE: begin
        if (start) begin
          shreg_d = frame_in;
          cnt_d   = len_in;
          crc_d   = '0;
          state_d = SH_BODY;
        end
      end
      SH_BODY: begin
        shreg_d = shreg_q << 1;
        crc_d   = (crc_q << 1) ^ (fb ? P_POLY : '0);
        if (cnt_q == LEN_W'(1)) begin
          cnt_d   = LEN_W'(P_CRC_W);
          state_d = SH_CRC;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SH_CRC: begin
        crc_d = crc_q << 1;
        if (cnt_q == LEN_W'(1)) begin
          state_d = SH_DONE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        state_d = SH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SH_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      crc_q   <= '0;
    end else begin
      state_q <= state_d;
      shreg_q <= shreg_d;
      cnt_q   <= cnt_d;
      crc_q   <= crc_d;
    end
  end

  assign idle      = (state_q == SH_IDLE);
  assign bit_valid = (state_q == SH_BODY) || (state_q == SH_CRC);
  assign bit_data  = (state_q == SH_CRC) ? crc_q[P_CRC_W-1] :
                     (state_q == SH_BODY) ? shreg_q[FRAME_MAX-1] : 1'b0;
  assign done      = (state_q == SH_DONE);

  AST_START_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> idle); // R10
  AST_START_OPENS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (start && idle) |=> bit_valid); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_AFTER_LAST_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!bit_valid && $past(bit_valid))); // R10
  AST_CRC_FULL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SH_BODY && state_d == SH_CRC) |=> (cnt_q == LEN_W'(P_CRC_W))); // R8

endmodule

// File: rtl/sbus_cmd_encoder.sv
module sbus_cmd_encoder
  import sbus_enc_pkg::*;
#(
  parameter int P_ID_W    = ID_W,
  parameter int P_ADDR_W  = ADDR_W,
  parameter int IN_ADDR_W = 32,
  parameter int P_REL_W   = REL_W,
  parameter int P_BYTES   = BYTES_MAX
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [P_ID_W-1:0]    req_id,
  input  logic [IN_ADDR_W-1:0] req_addr,
  input  logic [1:0]           req_size,
  input  logic                 req_write,
  input  logic [8*P_BYTES-1:0] req_wdata,
  output logic                 bit_valid,
  output logic                 bit_data,
  output logic                 frame_done
);

  localparam int FRAME_MAX = P_ID_W + 3 + 1 + P_ADDR_W + 1 + 8 * P_BYTES;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);

  logic [P_ADDR_W-1:0]  addr_m;
  form_e                form;
  logic [P_REL_W-1:0]   delta;
  logic [FRAME_MAX-1:0] frame;
  logic [LEN_W-1:0]     len;
  logic                 idle;
  logic                 accept;
  logic [P_ID_W-1:0]    pend_id_q;
  logic [P_ADDR_W-1:0]  pend_addr_q;

  assign addr_m    = req_addr[P_ADDR_W-1:0];
  assign req_ready = idle;
  assign accept    = req_valid && idle;

  // target of the frame in flight, for the history update at its end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_id_q   <= '0;
      pend_addr_q <= '0;
    end else if (accept) begin
      pend_id_q   <= req_id;
      pend_addr_q <= addr_m;
    end
  end

  sbus_addr_history #(
    .P_ID_W  (P_ID_W),
    .P_ADDR_W(P_ADDR_W),
    .P_REL_W (P_REL_W)
  ) i_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_id   (req_id),
    .lk_addr (addr_m),
    .lk_form (form),
    .lk_delta(delta),
    .upd_en  (frame_done),
    .upd_id  (pend_id_q),
    .upd_addr(pend_addr_q)
  );

  sbus_frame_pack #(
    .P_ID_W   (P_ID_W),
    .P_ADDR_W (P_ADDR_W),
    .P_REL_W  (P_REL_W),
    .P_BYTES  (P_BYTES),
    .FRAME_MAX(FRAME_MAX),
    .LEN_W    (LEN_W)
  ) i_pack (
    .id      (req_id),
    .form    (form),
    .write   (req_write),
    .abs_addr(addr_m),
    .delta   (delta),
    .size    (req_size),
    .wdata   (req_wdata),
    .frame   (frame),
    .len     (len)
  );

  sbus_bit_shifter #(
    .FRAME_MAX(FRAME_MAX),
    .LEN_W    (LEN_W)
  ) i_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .frame_in (frame),
    .len_in   (len),
    .idle     (idle),
    .bit_valid(bit_valid),
    .bit_data (bit_data),
    .done     (frame_done)
  );

  AST_NO_ACCEPT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid || frame_done) |-> !req_ready); // R10
  AST_READY_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> req_ready); // R10

endmodule

// File: tb/test_sbus_cmd_encoder.sv
module test_sbus_cmd_encoder;

  localparam int F_ABS = 0, F_REL = 1, F_SAME = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [1:0]  req_id;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic        req_write;
  logic [31:0] req_wdata;
  logic        bit_valid;
  logic        bit_data;
  logic        frame_done;

  int n_chk  = 0;
  int n_fail = 0;

  logic [20:0] m_last [4];

  logic [63:0] exp_v;
  int          exp_n;

  always #5 clk = ~clk;

  sbus_cmd_encoder i_sbus_cmd_encoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_id(req_id), .req_addr(req_addr), .req_size(req_size),
    .req_write(req_write), .req_wdata(req_wdata), .bit_valid(bit_valid),
    .bit_data(bit_data), .frame_done(frame_done)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic push(input logic [31:0] v, input int w);
    for (int i = w - 1; i >= 0; i--) begin
      exp_v[63 - exp_n] = v[i];
      exp_n++;
    end
  endtask

  // expected frame from the requirements; form chosen by the scenario
  task automatic build(input logic [1:0] id, input logic [31:0] addr, input logic [1:0] sz,
                       input logic wr, input logic [31:0] d, input int form);
    logic [20:0] a;
    logic [20:0] fld;
    logic [3:0]  c;
    int          fw;
    int          nb;
    a = addr[20:0];
    exp_v = '0;
    exp_n = 0;
    push(32'(id), 2);
    if (form == F_SAME) begin
      push(32'b11, 2);  fld = 21'(a[1:0]); fw = 2;
    end else if (form == F_REL) begin
      push(32'b101, 3); fld = 21'(9'(a - m_last[id])); fw = 9;
    end else begin
      push(32'b100, 3); fld = a; fw = 21;
    end
    push(32'(!wr), 1);
    nb = 1;
    if (sz == 2'b01) begin fld[0] = 1'b0; nb = 2; end
    if (sz[1]) begin fld[1:0] = 2'b01; nb = 4; end
    push(32'(fld), fw);
    push(32'(sz != 2'b00), 1);
    if (wr) for (int b = 0; b < nb; b++) push(32'(d[8*b +: 8]), 8);
    c = 4'h0;
    for (int i = 0; i < exp_n; i++) begin
      logic f;
      f = c[3] ^ exp_v[63 - i];
      c = {c[2:0], 1'b0} ^ (f ? 4'h3 : 4'h0);
    end
    push(32'(c), 4);
  endtask

  task automatic send(input string tag, input logic [1:0] id, input logic [31:0] addr,
                      input logic [1:0] sz, input logic wr, input logic [31:0] d, input int form);
    logic [63:0] got_v;
    int          got_n;
    logic        ready_bad;
    build(id, addr, sz, wr, d, form);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_id = id; req_addr = addr; req_size = sz;
    req_write = wr;   req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
    got_v = '0; got_n = 0; ready_bad = 1'b0;
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (!bit_valid) break;
      if (got_n < 64) got_v[63 - got_n] = bit_data;
      got_n++;
      if (req_ready) ready_bad = 1'b1;
    end
    check({tag, " frame length"}, 64'(got_n), 64'(exp_n));
    check({tag, " frame bits"}, got_v, exp_v);
    check({tag, " R10 done pulse / busy"}, {62'b0, frame_done, ready_bad}, 64'b10);
    @(negedge clk);
    check({tag, " R10 ready after done"}, {62'b0, req_ready, frame_done}, 64'b10);
    m_last[id] = addr[20:0];
  endtask

  task automatic t_reset_state;
    check("R10 reset ready/valid/done", {61'b0, req_ready, bit_valid, frame_done}, 64'b100);
  endtask

  task automatic t_absolute_first;
    send("R4 R5 R6 R7 R8 abs write 4B", 2'd0, 32'h0000_1000, 2'b10, 1'b1, 32'h1122_3344, F_ABS);
  endtask

  task automatic t_same_word;
    send("R2 same word read 1B", 2'd0, 32'h0000_1002, 2'b00, 1'b0, 32'h0, F_SAME);
  endtask

  task automatic t_rel_edges;
    send("R3 rel +255 read", 2'd0, 32'h0000_1101, 2'b00, 1'b0, 32'h0, F_REL);
    send("R3 R6 rel -256 write 2B", 2'd0, 32'h0000_1001, 2'b01, 1'b1, 32'h0000_A55A, F_REL);
  endtask

  task automatic t_rel_out_of_reach;
    send("R4 +256 goes absolute", 2'd0, 32'h0000_1101, 2'b00, 1'b0, 32'h0, F_ABS);
    send("R4 -257 goes absolute", 2'd0, 32'h0000_1000, 2'b00, 1'b1, 32'h0000_00C7, F_ABS);
  endtask

  task automatic t_mask_upper;
    send("R1 upper bits dropped abs", 2'd1, 32'hFFE0_ABCD, 2'b00, 1'b0, 32'h0, F_ABS);
    send("R1 upper bits ignored in compare", 2'd1, 32'h7F20_ABCD, 2'b00, 1'b0, 32'h0, F_SAME);
  endtask

  task automatic t_slave_indep;
    send("R9 other slave has own entry", 2'd2, 32'h0000_1000, 2'b00, 1'b0, 32'h0, F_ABS);
    send("R9 R6 R7 slot 0 kept, rel 4B", 2'd0, 32'h0000_1004, 2'b10, 1'b1, 32'hDEAD_BEEF, F_REL);
  endtask

  task automatic t_size_code3;
    send("R6 R7 size code 3 as 4 bytes", 2'd3, 32'h0015_5557, 2'b11, 1'b1, 32'hA1B2_C3D4, F_ABS);
  endtask

  task automatic t_reset_clears;
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R9 R10 reset mid-run outputs", {61'b0, req_ready, bit_valid, frame_done}, 64'b100);
    rst_n = 1'b1;
    send("R9 reset clears history", 2'd0, 32'h0000_1004, 2'b00, 1'b0, 32'h0, F_ABS);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_id = '0; req_addr = '0;
    req_size = '0; req_write = 1'b0; req_wdata = '0;
    repeat (3) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    t_absolute_first();
    t_same_word();
    t_rel_edges();
    t_rel_out_of_reach();
    t_mask_upper();
    t_slave_indep();
    t_size_code3();
    t_reset_clears();
    repeat (2) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule